// File: doc/BRIEF.md
# Command Slot Issue Scanner

This block keeps the pending-command bitmap for one storage port and hands pending slots, one at a time, to a single command engine. Software marks slots as pending by writing ones into the issue bitmap. Software cannot clear these bits. Only the engine's results clear them. The same register port also writes a port control word. Its start bit gates all dispatching. Two of its status bits are driven by hardware from enable bits in the same word.

A scan pass begins after a register write, or after a deferred recheck, when the start bit is set and at least one slot is pending. The pass visits pending slots from the lowest index to the highest. If the engine shows busy or data-request while a slot is being examined, that slot is skipped and stays pending. Otherwise the slot is offered through a request/acknowledge handshake, and the engine's busy state at acknowledge settles the outcome:
- If the engine is idle at acknowledge, the command finished at once and its bit clears.
- If the engine is busy at acknowledge, the slot is recorded as the one still executing and its bit stays set.

When the engine later signals that its transfer is done, a recheck runs one cycle after. If the recorded slot exists and the engine is idle, that slot's bit clears, the record returns to "none", and a new pass starts.

Top module: `slot_issue_sched`

## Requirements
- R1: After reset the issue bitmap and control word are zero, no request is offered, and the busy-slot tag reads all ones (the value -1, meaning none).
- R2: A write with `wr_sel_i`=1 ORs the data into the issue bitmap. Zero bits in the data never clear a pending bit.
- R3: No request is offered while control bit 0 (start) is clear. Setting it with slots pending makes a request appear.
- R4: Pending slots are offered in ascending index order, one at a time. The next slot is offered only after `eng_ack_i` for the current one, and the request and slot index hold until that acknowledge.
- R5: If `eng_busy_i` or `eng_drq_i` is high when a slot is examined, that slot is not offered and its bit stays set.
- R6: An acknowledge with busy and data-request both low clears that slot's issue bit.
- R7: An acknowledge with busy or data-request high leaves the bit set and loads the slot index into the busy-slot tag.
- R8: One cycle after an `eng_done_i` pulse, a recorded busy slot with the engine idle has its bit cleared and the tag returns to -1. A new scan pass then follows.
- R9: A recheck while the engine is still busy or requesting data changes neither the bitmap nor the tag.
- R10: A write with `wr_sel_i`=0 stores the control word, except that bit 15 is forced to equal written bit 0 and bit 14 is forced to equal written bit 4. Values written to bits 15 and 14 themselves are ignored.
- R11: A pass ends after the highest pending slot. With nothing pending, no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the control word, 1 selects the issue bitmap |
| wr_data_i | input | DATA_W | Write data |
| ctrl_o | output | DATA_W | Current control word |
| issue_o | output | NSLOT | Current issue bitmap |
| eng_req_o | output | 1 | Slot offered to the engine |
| eng_slot_o | output | SLOT_W | Index of the offered slot |
| eng_ack_i | input | 1 | Engine accepts the offered slot |
| eng_busy_i | input | 1 | Engine busy |
| eng_drq_i | input | 1 | Engine data request pending |
| eng_done_i | input | 1 | Engine transfer finished (one-cycle pulse) |
| busy_tag_o | output | SLOT_W+1 | Slot still executing, all ones when none |

## Verification
The bench checks the following cases, each of which would expose a specific fault:
- A busy acknowledge followed by a pass while the engine is still busy. A design that ignored the stall would offer slot 5 and lose ordering.
- A recheck that arrives while the engine is still busy. A design that cleared unconditionally would drop the executing slot's bit too early.
- A gapped bitmap with slots 0, 8 and 31 pending. An off-by-one in the scan pointer would repeat a slot, skip the top slot, or keep requesting after the last one.
- Writes of zeros into the bitmap and of ones into the two mirrored status bits. A design that stored these as written would let software clear work or fake running status.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SEEK  = 2'd1,
        SC_OFFER = 2'd2
    } scan_st_e;
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int NSLOT  = 32,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]  pend_i,
    input  logic [SLOT_W:0]   floor_i,
    output logic              found_o,
    output logic [SLOT_W-1:0] idx_o
);
    logic [NSLOT-1:0] elig;

    for (genvar g = 0; g < NSLOT; g++) begin : g_elig
        assign elig[g] = pend_i[g] & (floor_i <= (SLOT_W+1)'(g));
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found_o = 1'b1;
                idx_o   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/slot_issue_reg.sv
module slot_issue_reg #(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en_i,
    input  logic [NSLOT-1:0] set_mask_i,
    input  logic [NSLOT-1:0] clr_mask_i,
    output logic [NSLOT-1:0] issue_o
);
    logic [NSLOT-1:0] issue_d, issue_q;

    always_comb begin
        issue_d = issue_q & ~clr_mask_i;
        if (set_en_i) begin
            issue_d = issue_d | set_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) issue_q <= '0;
        else        issue_q <= issue_d;
    end

    assign issue_o = issue_q;

    AST_NO_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask_i == '0) |=> ((issue_q & $past(issue_q)) == $past(issue_q))); // R2
endmodule

// File: rtl/slot_ctrl_reg.sv
module slot_ctrl_reg #(
    parameter int DATA_W    = 32,
    parameter int START_BIT = 0,
    parameter int RXEN_BIT  = 4,
    parameter int RXRUN_BIT = 14,
    parameter int LRUN_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              start_o
);
    logic [DATA_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            ctrl_d            = wr_data_i;
            ctrl_d[LRUN_BIT]  = wr_data_i[START_BIT];
            ctrl_d[RXRUN_BIT] = wr_data_i[RXEN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o  = ctrl_q;
    assign start_o = ctrl_q[START_BIT];

    AST_LIST_RUN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[LRUN_BIT] == ctrl_q[START_BIT]); // R10
    AST_RX_RUN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ctrl_q[RXRUN_BIT] == $past(wr_data_i[RXEN_BIT])); // R10
endmodule

// File: rtl/slot_issue_sched.sv
module slot_issue_sched
    import slot_sched_pkg::*;
#(
    parameter int NSLOT     = 32,
    parameter int DATA_W    = 32,
    parameter int START_BIT = 0,
    parameter int RXEN_BIT  = 4,
    parameter int RXRUN_BIT = 14,
    parameter int LRUN_BIT  = 15,
    localparam int SLOT_W   = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [NSLOT-1:0]  issue_o,
    output logic              eng_req_o,
    output logic [SLOT_W-1:0] eng_slot_o,
    input  logic              eng_ack_i,
    input  logic              eng_busy_i,
    input  logic              eng_drq_i,
    input  logic              eng_done_i,
    output logic [SLOT_W:0]   busy_tag_o
);
    typedef struct packed {
        scan_st_e          st;
        logic [SLOT_W:0]   ptr;
        logic [SLOT_W-1:0] cur;
        logic              trig;
        logic              recheck;
        logic              bvld;
        logic [SLOT_W-1:0] bslot;
    } sched_t;

    sched_t            r_q, r_d;
    logic [NSLOT-1:0]  clr_mask;
    logic              start;
    logic              found;
    logic [SLOT_W-1:0] pick;
    logic              eng_stall;
    logic              take;

    slot_ctrl_reg #(
        .DATA_W(DATA_W), .START_BIT(START_BIT), .RXEN_BIT(RXEN_BIT),
        .RXRUN_BIT(RXRUN_BIT), .LRUN_BIT(LRUN_BIT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i & ~wr_sel_i), .wr_data_i(wr_data_i),
        .ctrl_o(ctrl_o), .start_o(start)
    );

    slot_issue_reg #(.NSLOT(NSLOT)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .set_en_i(wr_en_i & wr_sel_i), .set_mask_i(wr_data_i[NSLOT-1:0]),
        .clr_mask_i(clr_mask), .issue_o(issue_o)
    );

    slot_pick #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_pick (
        .pend_i(issue_o), .floor_i(r_q.ptr), .found_o(found), .idx_o(pick)
    );

    assign eng_stall  = eng_busy_i | eng_drq_i;
    assign eng_req_o  = (r_q.st == SC_OFFER) && start;
    assign eng_slot_o = r_q.cur;
    assign take       = eng_req_o & eng_ack_i;
    assign busy_tag_o = r_q.bvld ? {1'b0, r_q.bslot} : '1;

    always_comb begin
        r_d         = r_q;
        clr_mask    = '0;
        r_d.recheck = eng_done_i;

        if (r_q.recheck && r_q.bvld && !eng_stall) begin
            clr_mask[r_q.bslot] = 1'b1;
            r_d.bvld            = 1'b0;
        end

        case (r_q.st)
            SC_IDLE: begin
                if (r_q.trig) begin
                    r_d.trig = 1'b0;
                    if (start && (issue_o != '0)) begin
                        r_d.st  = SC_SEEK;
                        r_d.ptr = '0;
                    end
                end
            end
            SC_SEEK: begin
                if (!start || !found) begin
                    r_d.st = SC_IDLE;
                end else if (eng_stall) begin
                    r_d.ptr = {1'b0, pick} + 1'b1;
                end else begin
                    r_d.cur = pick;
                    r_d.st  = SC_OFFER;
                end
            end
            SC_OFFER: begin
                if (!start) begin
                    r_d.st = SC_IDLE;
                end else if (take) begin
                    if (eng_stall) begin
                        r_d.bvld  = 1'b1;
                        r_d.bslot = r_q.cur;
                    end else begin
                        clr_mask[r_q.cur] = 1'b1;
                    end
                    r_d.ptr = {1'b0, r_q.cur} + 1'b1;
                    r_d.st  = SC_SEEK;
                end
            end
            default: r_d.st = SC_IDLE;
        endcase

        if (wr_en_i || r_q.recheck) begin
            r_d.trig = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= SC_IDLE;
            r_q.ptr     <= '0;
            r_q.cur     <= '0;
            r_q.trig    <= 1'b0;
            r_q.recheck <= 1'b0;
            r_q.bvld    <= 1'b0;
            r_q.bslot   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> ctrl_o[START_BIT]); // R3
    AST_REQ_SLOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_o |-> issue_o[eng_slot_o]); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && !eng_ack_i && !wr_en_i) |=> (eng_req_o && $stable(eng_slot_o))); // R4
    AST_NO_OFFER_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req_o) |-> !$past(eng_stall)); // R5
    AST_BUSY_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        (take && eng_stall) |=> (busy_tag_o == {1'b0, $past(eng_slot_o)})); // R7
endmodule

// File: tb/slot_issue_sched_test.sv
module slot_issue_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl, issue;
    logic        eng_req;
    logic [4:0]  eng_slot;
    logic        eng_ack = 1'b0, eng_busy = 1'b0, eng_drq = 1'b0, eng_done = 1'b0;
    logic [5:0]  busy_tag;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    slot_issue_sched uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .ctrl_o(ctrl), .issue_o(issue),
        .eng_req_o(eng_req), .eng_slot_o(eng_slot), .eng_ack_i(eng_ack),
        .eng_busy_i(eng_busy), .eng_drq_i(eng_drq), .eng_done_i(eng_done),
        .busy_tag_o(busy_tag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_req(output bit ok);
        ok = 0;
        for (int i = 0; i < 20; i++) begin
            if (eng_req) begin ok = 1; return; end
            @(negedge clk);
        end
    endtask

    task automatic ack(input logic busy);
        eng_ack = 1'b1; eng_busy = busy;
        @(negedge clk);
        eng_ack = 1'b0;
    endtask

    task automatic no_req(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            if (eng_req) seen = 1;
            @(negedge clk);
        end
        chk(!seen, tag, {31'd0, seen}, 32'd0);
    endtask

    task automatic expect_slot(input logic [4:0] s, input string tag);
        bit ok;
        wait_req(ok);
        chk(ok && eng_slot == s, tag, {26'd0, ok, eng_slot}, {26'd0, 1'b1, s});
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(issue == 0, "R1 issue", issue, 0);
        chk(ctrl == 0, "R1 ctrl", ctrl, 0);
        chk(busy_tag == 6'h3F, "R1 tag", {26'd0, busy_tag}, 32'h3F);
        chk(!eng_req, "R1 req", {31'd0, eng_req}, 0);
    endtask

    task automatic t_or();
        wr(1'b1, 32'h5);
        wr(1'b1, 32'h2);
        chk(issue == 32'h7, "R2 or", issue, 32'h7);
        wr(1'b1, 32'h0);
        chk(issue == 32'h7, "R2 zero write", issue, 32'h7);
        no_req(10, "R3 no start");
    endtask

    task automatic t_ctrl_and_order();
        wr(1'b0, 32'h0000_C000);
        chk(ctrl == 32'h0, "R10 ignore status", ctrl, 32'h0);
        wr(1'b0, 32'h0000_0011);
        chk(ctrl == 32'h0000_C011, "R10 mirror", ctrl, 32'h0000_C011);
        expect_slot(5'd0, "R3 R4 slot0");
        ack(1'b0);
        chk(issue == 32'h6, "R6 clear0", issue, 32'h6);
        expect_slot(5'd1, "R4 slot1");
        ack(1'b0);
        expect_slot(5'd2, "R4 slot2");
        ack(1'b0);
        chk(issue == 32'h0, "R6 all clear", issue, 32'h0);
        no_req(8, "R11 empty");
    endtask

    task automatic t_busy();
        wr(1'b1, 32'h30);
        expect_slot(5'd4, "R4 slot4");
        ack(1'b1);
        chk(busy_tag == 6'd4, "R7 tag", {26'd0, busy_tag}, 4);
        chk(issue == 32'h30, "R7 bit kept", issue, 32'h30);
        no_req(10, "R5 stall skip");
        chk(issue == 32'h30, "R5 bits kept", issue, 32'h30);
        done_pulse();
        repeat (2) @(negedge clk);
        chk(busy_tag == 6'd4, "R9 tag kept", {26'd0, busy_tag}, 4);
        chk(issue == 32'h30, "R9 bit kept", issue, 32'h30);
        no_req(6, "R5 stall after recheck");
        eng_busy = 1'b0;
        done_pulse();
        chk(issue == 32'h20, "R8 clear", issue, 32'h20);
        chk(busy_tag == 6'h3F, "R8 tag none", {26'd0, busy_tag}, 32'h3F);
        expect_slot(5'd5, "R8 rescan");
        ack(1'b0);
        chk(issue == 32'h0, "R6 slot5", issue, 0);
    endtask

    task automatic t_stop();
        wr(1'b0, 32'h0);
        chk(ctrl == 32'h0, "R10 lrun off", ctrl, 0);
        wr(1'b1, 32'h1);
        no_req(10, "R3 stopped");
        wr(1'b0, 32'h1);
        expect_slot(5'd0, "R3 restart");
        ack(1'b0);
        chk(issue == 32'h0, "R6 restart clear", issue, 0);
    endtask

    task automatic t_gaps();
        wr(1'b1, 32'h8000_0101);
        expect_slot(5'd0, "R4 gap0");
        ack(1'b0);
        expect_slot(5'd8, "R4 gap8");
        ack(1'b0);
        expect_slot(5'd31, "R11 top slot");
        ack(1'b0);
        chk(issue == 32'h0, "R11 done", issue, 0);
        no_req(8, "R11 end pass");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_or();
        t_ctrl_and_order();
        t_busy();
        t_stop();
        t_gaps();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule